// File: doc/BRIEF.md
# GPIO Interrupt and Wake Status Aggregator

This block turns the filtered input levels of a bank of GPIO pins into latched interrupt and wake status, a grouped summary and one shared interrupt line. Each pin has its own configuration:
- a trigger mode that selects edge or level detection;
- a polarity field;
- an interrupt enable;
- a deliver bit that lets the pin reach the interrupt line;
- three wake enables, one for each sleep state.

Software clears the sticky status bits by writing ones. It re-arms the shared line with an end-of-interrupt strobe.

A global blocking feature guards against glitches while debounce settings are being changed. When blocking is enabled, any debounce configuration write stops status generation on every pin. The block lasts for a programmable number of slow-clock ticks. While it lasts, the interrupt enable bit of each pin reads back as zero. The register bus is outside this block: all accesses arrive as decoded write strobes and a read index.

Top module: `gpio_wake_irq_agg`

## Requirements
- R1: Configuration byte layout is: bit 7 trigger mode (0 edge, 1 level), bits 6:5 polarity (0 high, 1 low, 2 both, 3 reserved), bit 4 interrupt enable, bit 3 deliver, bits 2:0 wake enables. In edge mode the polarities work as follows: polarity 0 detects a rising edge, 1 a falling edge and 2 either edge. The edge is taken between the level sampled at one clock edge and the level sampled at the previous one. Polarity 3 never detects.
- R2: In level mode, polarity 0 detects while the level is 1 and polarity 1 detects while it is 0. Polarities 2 and 3 never detect. The status is re-set on every clock while the level persists, so a clear takes effect only once the level has gone away.
- R3: A detection sets the pin's interrupt status on the following clock edge only if the pin's interrupt enable is 1.
- R4: Clear strobe bit 0 clears the selected pin's interrupt status and bit 1 clears its wake status. A detection in the same cycle wins over the clear.
- R5: The pending state of a pin is the OR of its interrupt status and its wake status. Summary bit g is the OR of the pending states of pins 4g to 4g+3, which gives 46 bits for the default 184 pins.
- R6: The interrupt line rises one cycle after the block is armed and some pending pin has deliver set. It then stays high until an end-of-interrupt strobe. Pending pins with deliver cleared never raise it.
- R7: An end-of-interrupt strobe drops the line on the next clock edge and re-arms it. If unmasked pending pins remain, the line rises again one cycle later.
- R8: Sleep-state code 0 is running, 1 is the lightest sleep state, 2 the middle one and 3 the deepest; codes 1 to 3 select wake enable bit 0, 1 and 2 respectively. A detection sets the wake status when the selected wake enable is set. In the running state the wake status is never set. The wake request is high when some pin has wake status together with the wake enable for the present sleep state.
- R9: With blocking enabled and a nonzero length, a debounce write starts a block that lasts for that length of slow ticks. A later debounce write reloads the length. During the block no status bit is set on any pin, and the read-back interrupt enable is 0.
- R10: After reset, all configuration and status are zero, the interrupt line is low, the block is armed, and blocking is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NUM_PINS | Filtered pin levels |
| sleep_state | input | 2 | Current sleep state code |
| slow_tick | input | 1 | Slow-clock tick that times the block |
| cfg_we | input | 1 | Pin configuration write strobe |
| cfg_pin | input | PW | Pin index for configuration write |
| cfg_data | input | 8 | New configuration byte |
| db_we | input | 1 | Debounce configuration write strobe (any pin) |
| clr_we | input | 1 | Status clear strobe |
| clr_pin | input | PW | Pin index for clear |
| clr_bits | input | 2 | Bit 0 clears interrupt status, bit 1 wake status |
| mst_we | input | 1 | Master blocking-setting write strobe |
| mst_blk_en | input | 1 | New blocking enable |
| mst_blk_len | input | BLK_W | New blocking length in slow ticks |
| eoi_we | input | 1 | End-of-interrupt strobe |
| rd_pin | input | PW | Pin index for read-back |
| rd_cfg | output | 8 | Configuration of rd_pin, interrupt enable hidden while blocked |
| rd_int_sts | output | 1 | Interrupt status of rd_pin |
| rd_wake_sts | output | 1 | Wake status of rd_pin |
| summary | output | NGRP | Pending summary, one bit per four pins |
| irq | output | 1 | Shared interrupt line |
| wake_req | output | 1 | Wake request |

## Verification
The bench holds a level input high in level mode and clears the status there. A design that does not re-set level status would report the pin idle while its level is still active. The bench gives an end-of-interrupt while unmasked pins are still pending. A missing re-arm would leave the line dead, and a line that is not latched would stay high after the strobe. Random traffic crosses debounce writes with the blocking length. A counter that reloads late or that ignores its enable lets status leak through, or else it hides the interrupt enable for too long. Both the lowest and the highest pin groups are toggled, so a summary group with an offset error shows up.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [1:0] {
        POL_HIGH = 2'd0,
        POL_LOW  = 2'd1,
        POL_BOTH = 2'd2,
        POL_RSVD = 2'd3
    } pol_sel_e;

    typedef enum logic [1:0] {
        SLP_RUN   = 2'd0,
        SLP_LIGHT = 2'd1,
        SLP_MID   = 2'd2,
        SLP_DEEP  = 2'd3
    } sleep_e;

    typedef struct packed {
        logic       trig_lvl;
        pol_sel_e   pol;
        logic       int_en;
        logic       deliver;
        logic [2:0] wake_en;
    } pin_cfg_t;

    localparam int CFG_W     = $bits(pin_cfg_t);
    localparam int INT_EN_BIT = 4;

    function automatic logic evt_hit(pin_cfg_t c, logic lvl, logic prv);
        logic r;
        r = 1'b0;
        if (c.trig_lvl) begin
            case (c.pol)
                POL_HIGH: r = lvl;
                POL_LOW:  r = ~lvl;
                default:  r = 1'b0;
            endcase
        end else begin
            case (c.pol)
                POL_HIGH: r = lvl & ~prv;
                POL_LOW:  r = ~lvl & prv;
                POL_BOTH: r = lvl ^ prv;
                default:  r = 1'b0;
            endcase
        end
        return r;
    endfunction

    function automatic logic wake_sel(logic [2:0] en, sleep_e s);
        logic r;
        case (s)
            SLP_LIGHT: r = en[0];
            SLP_MID:   r = en[1];
            SLP_DEEP:  r = en[2];
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_pin_evt.sv
module gpio_pin_evt
    import gpio_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    input  logic     cfg_hit,
    input  pin_cfg_t cfg_new,
    input  sleep_e   sleep,
    input  logic     blocked,
    input  logic     clr_int,
    input  logic     clr_wake,
    output pin_cfg_t cfg,
    output logic     int_sts,
    output logic     wake_sts,
    output logic     wake_live
);
    logic prv;
    logic hit;
    logic set_int;
    logic set_wake;

    assign hit      = evt_hit(cfg, lvl, prv);
    assign set_int  = hit & cfg.int_en & ~blocked;
    assign set_wake = hit & wake_sel(cfg.wake_en, sleep) & ~blocked;
    assign wake_live = wake_sts & wake_sel(cfg.wake_en, sleep);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv      <= 1'b0;
            cfg      <= '0;
            int_sts  <= 1'b0;
            wake_sts <= 1'b0;
        end else begin
            prv      <= lvl;
            if (cfg_hit) cfg <= cfg_new;
            int_sts  <= set_int  | (int_sts  & ~clr_int);
            wake_sts <= set_wake | (wake_sts & ~clr_wake);
        end
    end
endmodule

// File: rtl/gpio_blk_timer.sv
module gpio_blk_timer #(
    parameter int BLK_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mst_we,
    input  logic             en_in,
    input  logic [BLK_W-1:0] len_in,
    input  logic             db_we,
    input  logic             tick,
    output logic             blocking
);
    logic             blk_en;
    logic [BLK_W-1:0] blk_len;
    logic [BLK_W-1:0] cnt;

    assign blocking = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_en  <= 1'b0;
            blk_len <= '0;
            cnt     <= '0;
        end else begin
            if (db_we && blk_en)
                cnt <= blk_len;
            else if (tick && blocking)
                cnt <= cnt - 1'b1;
            if (mst_we) begin
                blk_en  <= en_in;
                blk_len <= len_in;
            end
        end
    end
endmodule

// File: rtl/gpio_irq_gate.sv
module gpio_irq_gate (
    input  logic clk,
    input  logic rst,
    input  logic any_unm,
    input  logic eoi_we,
    output logic irq
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
            irq   <= 1'b0;
        end else if (eoi_we) begin
            armed <= 1'b1;
            irq   <= 1'b0;
        end else if (armed && any_unm) begin
            armed <= 1'b0;
            irq   <= 1'b1;
        end
    end
endmodule

// File: rtl/gpio_wake_irq_agg.sv
module gpio_wake_irq_agg
    import gpio_evt_pkg::*;
#(
    parameter  int NUM_PINS = 184,
    parameter  int BLK_W    = 12,
    localparam int PW       = $clog2(NUM_PINS),
    localparam int NGRP     = (NUM_PINS + 3) / 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [1:0]          sleep_state,
    input  logic                slow_tick,
    input  logic                cfg_we,
    input  logic [PW-1:0]       cfg_pin,
    input  logic [7:0]          cfg_data,
    input  logic                db_we,
    input  logic                clr_we,
    input  logic [PW-1:0]       clr_pin,
    input  logic [1:0]          clr_bits,
    input  logic                mst_we,
    input  logic                mst_blk_en,
    input  logic [BLK_W-1:0]    mst_blk_len,
    input  logic                eoi_we,
    input  logic [PW-1:0]       rd_pin,
    output logic [7:0]          rd_cfg,
    output logic                rd_int_sts,
    output logic                rd_wake_sts,
    output logic [NGRP-1:0]     summary,
    output logic                irq,
    output logic                wake_req
);
    localparam int PAD_W = NGRP * 4;

    sleep_e              sleep;
    pin_cfg_t            cfg_new;
    pin_cfg_t            cfg_arr [NUM_PINS];
    logic [NUM_PINS-1:0] int_sts_all;
    logic [NUM_PINS-1:0] wake_sts_all;
    logic [NUM_PINS-1:0] wake_live_all;
    logic [NUM_PINS-1:0] deliver_all;
    logic [NUM_PINS-1:0] pend_all;
    logic [PAD_W-1:0]    pend_pad;
    logic                blocking;
    logic                any_unm;

    assign sleep   = sleep_e'(sleep_state);
    assign cfg_new = pin_cfg_t'(cfg_data);

    gpio_blk_timer #(.BLK_W(BLK_W)) u_blk (
        .clk      (clk),
        .rst      (rst),
        .mst_we   (mst_we),
        .en_in    (mst_blk_en),
        .len_in   (mst_blk_len),
        .db_we    (db_we),
        .tick     (slow_tick),
        .blocking (blocking)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic hit_cfg;
        logic hit_clr;
        assign hit_cfg = cfg_we && (cfg_pin == PW'(g));
        assign hit_clr = clr_we && (clr_pin == PW'(g));

        gpio_pin_evt u_pin (
            .clk       (clk),
            .rst       (rst),
            .lvl       (pin_lvl[g]),
            .cfg_hit   (hit_cfg),
            .cfg_new   (cfg_new),
            .sleep     (sleep),
            .blocked   (blocking),
            .clr_int   (hit_clr & clr_bits[0]),
            .clr_wake  (hit_clr & clr_bits[1]),
            .cfg       (cfg_arr[g]),
            .int_sts   (int_sts_all[g]),
            .wake_sts  (wake_sts_all[g]),
            .wake_live (wake_live_all[g])
        );

        assign deliver_all[g] = cfg_arr[g].deliver;
    end

    assign pend_all = int_sts_all | wake_sts_all;
    assign any_unm  = |(pend_all & deliver_all);
    assign wake_req = |wake_live_all;

    if (PAD_W > NUM_PINS) begin : g_pad
        assign pend_pad = {{(PAD_W - NUM_PINS){1'b0}}, pend_all};
    end else begin : g_nopad
        assign pend_pad = pend_all;
    end

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        assign summary[k] = |pend_pad[4*k +: 4];
    end

    gpio_irq_gate u_irq (
        .clk     (clk),
        .rst     (rst),
        .any_unm (any_unm),
        .eoi_we  (eoi_we),
        .irq     (irq)
    );

    always_comb begin
        rd_cfg      = '0;
        rd_int_sts  = 1'b0;
        rd_wake_sts = 1'b0;
        if (32'(rd_pin) < NUM_PINS) begin
            rd_cfg      = cfg_arr[rd_pin];
            rd_int_sts  = int_sts_all[rd_pin];
            rd_wake_sts = wake_sts_all[rd_pin];
            if (blocking) rd_cfg[INT_EN_BIT] = 1'b0;
        end
    end
endmodule

module gpio_agg_checker #(
    parameter int NUM_PINS = 184
) (
    input logic                clk,
    input logic                rst,
    input logic                irq,
    input logic                eoi_we,
    input logic                any_unm,
    input logic                blocking,
    input logic [7:0]          rd_cfg,
    input logic [NUM_PINS-1:0] int_sts_all
);
    a_r7_eoi_drops: assert property (@(posedge clk) disable iff (rst)
        eoi_we |=> !irq);

    a_r6_line_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !eoi_we) |=> irq);

    a_r6_rise_needs_pending: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(any_unm));

    a_r9_no_new_status: assert property (@(posedge clk) disable iff (rst)
        blocking |=> ((int_sts_all & ~$past(int_sts_all)) == '0));

    a_r9_enable_hidden: assert property (@(posedge clk) disable iff (rst)
        blocking |-> !rd_cfg[4]);
endmodule

bind gpio_wake_irq_agg gpio_agg_checker #(.NUM_PINS(NUM_PINS)) u_agg_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .eoi_we      (eoi_we),
    .any_unm     (any_unm),
    .blocking    (blocking),
    .rd_cfg      (rd_cfg),
    .int_sts_all (int_sts_all)
);

// File: tb/test_gpio_wake_irq_agg.sv
`timescale 1ns/1ps
module test_gpio_wake_irq_agg;
    localparam int NP    = 184;
    localparam int BW    = 12;
    localparam int PW    = $clog2(NP);
    localparam int NG    = (NP + 3) / 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_lvl;
    logic [1:0]    sleep_state;
    logic          slow_tick, cfg_we, db_we, clr_we, mst_we, mst_blk_en, eoi_we;
    logic [PW-1:0] cfg_pin, clr_pin, rd_pin;
    logic [7:0]    cfg_data, rd_cfg;
    logic [1:0]    clr_bits;
    logic [BW-1:0] mst_blk_len;
    logic          rd_int_sts, rd_wake_sts, irq, wake_req;
    logic [NG-1:0] summary;

    always #4 clk = ~clk;

    gpio_wake_irq_agg #(.NUM_PINS(NP), .BLK_W(BW)) i_gpio_wake_irq_agg (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .sleep_state(sleep_state),
        .slow_tick(slow_tick), .cfg_we(cfg_we), .cfg_pin(cfg_pin),
        .cfg_data(cfg_data), .db_we(db_we), .clr_we(clr_we), .clr_pin(clr_pin),
        .clr_bits(clr_bits), .mst_we(mst_we), .mst_blk_en(mst_blk_en),
        .mst_blk_len(mst_blk_len), .eoi_we(eoi_we), .rd_pin(rd_pin),
        .rd_cfg(rd_cfg), .rd_int_sts(rd_int_sts), .rd_wake_sts(rd_wake_sts),
        .summary(summary), .irq(irq), .wake_req(wake_req)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0]    m_cfg  [NP];
    bit            m_int  [NP];
    bit            m_wk   [NP];
    bit            m_prev [NP];
    bit            m_irq, m_arm, m_ben;
    logic [BW-1:0] m_len, m_cnt;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // detection per R1/R2 using the byte layout of R1
    function automatic bit f_evt(logic [7:0] c, bit lv, bit pv);
        bit lvlmode = c[7];
        logic [1:0] pol = c[6:5];
        if (lvlmode) return (pol == 2'd0 && lv) || (pol == 2'd1 && !lv);
        if (pol == 2'd0) return lv && !pv;
        if (pol == 2'd1) return !lv && pv;
        if (pol == 2'd2) return lv != pv;
        return 0;
    endfunction

    // wake enable selection per R8
    function automatic bit f_wen(logic [7:0] c, logic [1:0] s);
        if (s == 2'd0) return 0;
        return c[s - 1];
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_cfg[p] = '0; m_int[p] = 0; m_wk[p] = 0; m_prev[p] = 0;
        end
        m_irq = 0; m_arm = 1; m_ben = 0; m_len = '0; m_cnt = '0;
    endtask

    task automatic idle_inputs();
        slow_tick = 0; cfg_we = 0; db_we = 0; clr_we = 0; mst_we = 0;
        eoi_we = 0; clr_bits = 2'b00; mst_blk_en = 0; mst_blk_len = '0;
        cfg_pin = '0; clr_pin = '0; cfg_data = '0;
    endtask

    task automatic step();
        bit any, blk, ev, si, sw, ci, cw;
        bit exp_wake;
        logic [NG-1:0] exp_sum;
        logic [7:0] exp_cfg;
        any = 0;
        for (int p = 0; p < NP; p++)
            if (m_cfg[p][3] && (m_int[p] || m_wk[p])) any = 1;
        blk = (m_cnt != 0);
        for (int p = 0; p < NP; p++) begin
            ev = f_evt(m_cfg[p], pin_lvl[p], m_prev[p]);
            si = ev && m_cfg[p][4] && !blk;
            sw = ev && f_wen(m_cfg[p], sleep_state) && !blk;
            ci = clr_we && (clr_pin == PW'(p)) && clr_bits[0];
            cw = clr_we && (clr_pin == PW'(p)) && clr_bits[1];
            m_int[p]  = si || (m_int[p] && !ci);
            m_wk[p]   = sw || (m_wk[p] && !cw);
            m_prev[p] = pin_lvl[p];
            if (cfg_we && cfg_pin == PW'(p)) m_cfg[p] = cfg_data;
        end
        if (db_we && m_ben) m_cnt = m_len;
        else if (slow_tick && m_cnt != 0) m_cnt = m_cnt - 1;
        if (mst_we) begin m_ben = mst_blk_en; m_len = mst_blk_len; end
        if (eoi_we) begin m_irq = 0; m_arm = 1; end
        else if (m_arm && any) begin m_irq = 1; m_arm = 0; end
        @(posedge clk);
        #2;
        exp_sum = '0;
        exp_wake = 0;
        for (int p = 0; p < NP; p++) begin
            if (m_int[p] || m_wk[p]) exp_sum[p/4] = 1'b1;
            if (m_wk[p] && f_wen(m_cfg[p], sleep_state)) exp_wake = 1;
        end
        exp_cfg = m_cfg[rd_pin];
        if (m_cnt != 0) exp_cfg[4] = 1'b0;
        chk("R5 summary", 64'(summary), 64'(exp_sum));
        chk("R6 irq", 64'(irq), 64'(m_irq));
        chk("R8 wake_req", 64'(wake_req), 64'(exp_wake));
        chk("R3 rd_int_sts", 64'(rd_int_sts), 64'(m_int[rd_pin]));
        chk("R8 rd_wake_sts", 64'(rd_wake_sts), 64'(m_wk[rd_pin]));
        chk("R9 rd_cfg", 64'(rd_cfg), 64'(exp_cfg));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        idle_inputs();
        pin_lvl = '0; sleep_state = 2'd0; rd_pin = PW'(5);
        rst = 1;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        model_reset();
        #1;
        chk("R10 irq", 64'(irq), 64'd0);
        chk("R10 summary", 64'(summary), 64'd0);
        chk("R10 rd_cfg", 64'(rd_cfg), 64'd0);

        // R1: edge, rising, enabled, delivered
        cfg_we = 1; cfg_pin = PW'(5); cfg_data = 8'h18;
        step(); idle_inputs();
        pin_lvl[5] = 1; step();
        chk("R1 rising edge status", 64'(rd_int_sts), 64'd1);
        // R4: clear with no new edge
        clr_we = 1; clr_pin = PW'(5); clr_bits = 2'b01; step(); idle_inputs();
        chk("R4 cleared", 64'(rd_int_sts), 64'd0);
        chk("R6 irq after pending", 64'(irq), 64'd1);
        // R2: level high, clear while still high
        cfg_we = 1; cfg_pin = PW'(5); cfg_data = 8'h98; step(); idle_inputs();
        step();
        clr_we = 1; clr_pin = PW'(5); clr_bits = 2'b01; step(); idle_inputs();
        chk("R2 level re-sets", 64'(rd_int_sts), 64'd1);
        pin_lvl[5] = 0; clr_we = 1; clr_pin = PW'(5); clr_bits = 2'b01;
        step(); idle_inputs();
        chk("R2 clear after level gone", 64'(rd_int_sts), 64'd0);
        // R7: end of interrupt with nothing pending
        eoi_we = 1; step(); idle_inputs();
        chk("R7 eoi drops irq", 64'(irq), 64'd0);
        step();
        chk("R7 stays low when idle", 64'(irq), 64'd0);
        // R1: falling edge on pin 181 (top group)
        rd_pin = PW'(181);
        pin_lvl[181] = 1; cfg_we = 1; cfg_pin = PW'(181); cfg_data = 8'h38;
        step(); idle_inputs();
        pin_lvl[181] = 0; step();
        chk("R1 falling edge status", 64'(rd_int_sts), 64'd1);
        chk("R5 top group", 64'(summary[45]), 64'd1);

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            idle_inputs();
            for (int p = 0; p < 16; p++) begin
                if ($urandom % 40 == 0) pin_lvl[p] = ~pin_lvl[p];
                if ($urandom % 40 == 0) pin_lvl[168+p] = ~pin_lvl[168+p];
            end
            if ($urandom % 50 == 0) sleep_state = 2'($urandom);
            r = $urandom % 100;
            if (r < 20) begin
                cfg_we = 1;
                cfg_pin = ($urandom % 2 == 1) ? PW'($urandom % 16) : PW'(168 + $urandom % 16);
                cfg_data = 8'($urandom);
            end
            if ($urandom % 100 < 35) begin
                clr_we = 1;
                clr_pin = ($urandom % 2 == 1) ? PW'($urandom % 16) : PW'(168 + $urandom % 16);
                clr_bits = 2'($urandom);
            end
            if ($urandom % 100 < 8)  eoi_we = 1;
            if ($urandom % 100 < 4)  db_we = 1;
            if ($urandom % 100 < 3) begin
                mst_we = 1; mst_blk_en = 1'($urandom); mst_blk_len = BW'($urandom % 6);
            end
            slow_tick = ($urandom % 3 == 0);
            if ($urandom % 10 == 0)
                rd_pin = ($urandom % 2 == 1) ? PW'($urandom % 16) : PW'(168 + $urandom % 16);
            step();
        end
        idle_inputs();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule